// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a register of WIDTH edge-triggered flip-flops (eight by default) whose next contents are picked by a two-bit mode select. On every rising clock edge it does one of four things. It can take a full parallel word. It can move every bit one place toward the most significant end, or one place toward the least significant end. Or it can keep what it has. Each end of the register has its own serial input. `ser_lo` feeds bit 0 when shifting upward, and `ser_hi` feeds bit WIDTH-1 when shifting downward.

The select word is decoded into one of four named operating states: LOAD (`sel`=00), UP (`sel`=01), DOWN (`sel`=10) and KEEP (`sel`=11). The decode happens again on every edge. Any state can be followed by any other state on the next edge, so each transition is simply the value `sel` has at that edge: LOAD->UP, UP->DOWN, DOWN->KEEP, KEEP->LOAD, and so on. An unknown select value decodes to KEEP. A synchronous active-high reset clears the register and wins over every operating state. The outputs come straight from the flip-flops.

Top module: `usr_shift_reg`

## Requirements
- R1: When `rst` is 1 at a rising edge, `q` becomes all zeros after that edge, whatever `sel`, `par_in`, `ser_lo` and `ser_hi` are.
- R2: With `sel`=00 (LOAD), a rising edge copies `par_in` into `q`, bit for bit. `ser_lo` and `ser_hi` have no effect.
- R3: With `sel`=01 (UP), a rising edge sets `q[i]` to the old `q[i-1]` for i from 1 to WIDTH-1, and sets `q[0]` to `ser_lo`. `ser_hi` and `par_in` have no effect.
- R4: With `sel`=10 (DOWN), a rising edge sets `q[i]` to the old `q[i+1]` for i from 0 to WIDTH-2, and sets `q[WIDTH-1]` to `ser_hi`. `ser_lo` and `par_in` have no effect.
- R5: With `sel`=11 (KEEP), a rising edge leaves `q` unchanged, whatever the data inputs are.
- R6: `q` changes only at a rising clock edge. Changes on `sel`, `par_in`, `ser_lo` or `ser_hi` while the clock is steady high or steady low leave `q` as it is, so there is no combinational path from any input to `q`.
- R7: WIDTH consecutive UP edges fill `q` entirely with the serial stream from `ser_lo`, with the first bit ending in `q[WIDTH-1]`. WIDTH consecutive DOWN edges fill `q` entirely from `ser_hi`, with the first bit ending in `q[0]`. Nothing of the earlier contents remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| sel | input | 2 | Mode select: 00 LOAD, 01 UP, 10 DOWN, 11 KEEP |
| par_in | input | WIDTH | Parallel data word for LOAD |
| ser_lo | input | 1 | Serial input entering bit 0 in UP |
| ser_hi | input | 1 | Serial input entering bit WIDTH-1 in DOWN |
| q | output | WIDTH | Registered register contents |

## Verification
Every clock cycle, the assertions check the next contents for each operating state: the reset clear, the parallel copy, both one-place shifts with the correct serial input entering at the correct end, and the unchanged value in KEEP. Because the assertions only sample at rising edges, they cannot see that `q` stays put between edges. The bench's scenarios show that by toggling every input while the clock is high and while it is low. The bench also runs the full drain sequences in both directions, where a whole word is replaced one bit at a time.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_KEEP = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0]  sel,
    output shift_mode_e mode
);

    always_comb begin
        case (sel)
            2'b00:   mode = MODE_LOAD;
            2'b01:   mode = MODE_UP;
            2'b10:   mode = MODE_DOWN;
            default: mode = MODE_KEEP;
        endcase
    end

endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  shift_mode_e mode,
    input  logic        par,
    input  logic        from_lo,
    input  logic        from_hi,
    output logic        q
);

    logic q_next;

    always_comb begin
        unique case (mode)
            MODE_LOAD: q_next = par;
            MODE_UP:   q_next = from_lo;
            MODE_DOWN: q_next = from_hi;
            MODE_KEEP: q_next = q;
            default:   q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_lo,
    input  logic             ser_hi,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    shift_mode_e      mode;
    logic [WIDTH-1:0] bits;
    logic [WIDTH-1:0] feed_lo;
    logic [WIDTH-1:0] feed_hi;

    usr_mode_decode u_decode (
        .sel  (sel),
        .mode (mode)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == 0) begin : g_lo_end
            assign feed_lo[i] = ser_lo;
        end else begin : g_lo_mid
            assign feed_lo[i] = bits[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign feed_hi[i] = ser_hi;
        end else begin : g_hi_mid
            assign feed_hi[i] = bits[i+1];
        end

        usr_bit_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .par     (par_in[i]),
            .from_lo (feed_lo[i]),
            .from_hi (feed_hi[i]),
            .q       (bits[i])
        );
    end

    assign q = bits;

endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_lo,
    input logic             ser_hi,
    input logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> q == '0);

    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b00) |=> q == $past(par_in));

    a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b01) |=> q == {$past(q[TOP-1:0]), $past(ser_lo)});

    a_r4_shift_down: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b10) |=> q == {$past(ser_hi), $past(q[TOP:1])});

    a_r5_keep_stable: assert property (@(posedge clk) disable iff (rst)
        (!rst && sel == 2'b11) |=> $stable(q));

endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .par_in (par_in),
    .ser_lo (ser_lo),
    .ser_hi (ser_hi),
    .q      (q)
);

// File: tb/usr_shift_reg_tb_top.sv
module usr_shift_reg_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   sel;
    logic [W-1:0] par_in;
    logic         ser_lo;
    logic         ser_hi;
    logic [W-1:0] q;

    logic [W-1:0] mdl;
    int           total = 0;
    int           bad   = 0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .par_in (par_in),
        .ser_lo (ser_lo),
        .ser_hi (ser_hi),
        .q      (q)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: q=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic r, input logic [1:0] s,
                        input logic [W-1:0] p, input logic lo, input logic hi);
        @(negedge clk);
        rst = r; sel = s; par_in = p; ser_lo = lo; ser_hi = hi;
        if (r) mdl = '0;
        else begin
            case (s)
                2'b00:   mdl = p;
                2'b01:   mdl = {mdl[W-2:0], lo};
                2'b10:   mdl = {hi, mdl[W-1:1]};
                default: mdl = mdl;
            endcase
        end
        @(posedge clk);
        #2;
        check(tag, q, mdl);
    endtask

    task automatic t_reset;
        step("R1 reset over load", 1'b1, 2'b00, 8'hFF, 1'b1, 1'b1);
        step("R2 load before reset", 1'b0, 2'b00, 8'h5A, 1'b0, 1'b0);
        step("R1 reset over shift up", 1'b1, 2'b01, 8'h00, 1'b1, 1'b1);
        step("R2 load before reset", 1'b0, 2'b00, 8'hC3, 1'b0, 1'b0);
        step("R1 reset over keep", 1'b1, 2'b11, 8'hFF, 1'b1, 1'b1);
    endtask

    task automatic t_load;
        step("R2 load A5 serial high", 1'b0, 2'b00, 8'hA5, 1'b1, 1'b1);
        step("R2 load 3C serial low", 1'b0, 2'b00, 8'h3C, 1'b0, 1'b0);
        step("R2 load FF", 1'b0, 2'b00, 8'hFF, 1'b0, 1'b1);
        step("R2 load 00", 1'b0, 2'b00, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_shift_up;
        step("R2 load 81", 1'b0, 2'b00, 8'h81, 1'b0, 1'b0);
        step("R3 up ser_lo=1 ser_hi=0", 1'b0, 2'b01, 8'hFF, 1'b1, 1'b0);
        step("R3 up ser_lo=0 ser_hi=1", 1'b0, 2'b01, 8'h00, 1'b0, 1'b1);
        step("R3 up ser_lo=1 ser_hi=1", 1'b0, 2'b01, 8'h55, 1'b1, 1'b1);
        step("R3 up ser_lo=0 ser_hi=0", 1'b0, 2'b01, 8'hAA, 1'b0, 1'b0);
    endtask

    task automatic t_shift_down;
        step("R2 load 81", 1'b0, 2'b00, 8'h81, 1'b0, 1'b0);
        step("R4 down ser_hi=1 ser_lo=0", 1'b0, 2'b10, 8'hFF, 1'b0, 1'b1);
        step("R4 down ser_hi=0 ser_lo=1", 1'b0, 2'b10, 8'h00, 1'b1, 1'b0);
        step("R4 down ser_hi=1 ser_lo=1", 1'b0, 2'b10, 8'h55, 1'b1, 1'b1);
        step("R4 down ser_hi=0 ser_lo=0", 1'b0, 2'b10, 8'hAA, 1'b0, 1'b0);
    endtask

    task automatic t_keep;
        step("R2 load 96", 1'b0, 2'b00, 8'h96, 1'b0, 1'b0);
        step("R5 keep par FF", 1'b0, 2'b11, 8'hFF, 1'b1, 1'b1);
        step("R5 keep par 00", 1'b0, 2'b11, 8'h00, 1'b0, 1'b0);
        step("R5 keep par 69", 1'b0, 2'b11, 8'h69, 1'b1, 1'b0);
    endtask

    task automatic t_between_edges;
        step("R2 load 4B", 1'b0, 2'b00, 8'h4B, 1'b0, 1'b0);
        sel = 2'b00; par_in = 8'hFF; ser_lo = 1'b1; ser_hi = 1'b1;
        #1 check("R6 clock high, load select", q, mdl);
        sel = 2'b01;
        #1 check("R6 clock high, up select", q, mdl);
        @(negedge clk);
        #1 sel = 2'b10; par_in = 8'h00; ser_lo = 1'b0;
        #1 check("R6 clock low, down select", q, mdl);
        sel = 2'b00;
        #1 check("R6 clock low, load select", q, mdl);
        sel = 2'b11;
        @(posedge clk);
        #2 check("R6 keep after toggles", q, mdl);
    endtask

    task automatic t_drain;
        logic [W-1:0] pat;
        pat = 8'b1011_0010;
        step("R2 load 5A for up drain", 1'b0, 2'b00, 8'h5A, 1'b0, 1'b0);
        for (int k = W - 1; k >= 0; k--) begin
            step("R7 up drain step", 1'b0, 2'b01, 8'h00, pat[k], ~pat[k]);
        end
        check("R7 up drain result", q, pat);
        pat = 8'b0110_1101;
        step("R2 load A5 for down drain", 1'b0, 2'b00, 8'hA5, 1'b0, 1'b0);
        for (int k = 0; k < W; k++) begin
            step("R7 down drain step", 1'b0, 2'b10, 8'hFF, ~pat[k], pat[k]);
        end
        check("R7 down drain result", q, pat);
    endtask

    initial begin
        rst = 1'b1; sel = 2'b11; par_in = '0; ser_lo = 1'b0; ser_hi = 1'b0;
        mdl = '0;
        @(posedge clk);
        @(posedge clk);
        #2 check("R1 reset state", q, 8'h00);
        t_reset();
        t_load();
        t_shift_up();
        t_shift_down();
        t_keep();
        t_between_edges();
        t_drain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule